// File: doc/BRIEF.md
# Programmable Repeating-Pattern Loop Code Detector

This block monitors a serial receive bit stream, one bit per `bit_en` strobe. It looks for repeating codes that software programs. Three detectors run side by side: loop-up, loop-down and a spare. Each detector has a 16-bit code held in two byte registers and its own pattern length: 1 to 8 bits or 16 bits. The phase of the incoming pattern is not known in advance. While a detector is unlocked, it slips its pattern pointer one extra position on every mismatch until it finds alignment. After 32 consecutive good compares it locks, and stops slipping.

Each detector counts compared bits and mismatches over an integration window of `WIN_BITS` strobes. The default is 74112 strobes, which is 48 ms at 1.544 Mb/s. At the end of each window, the detector's real-time status becomes 1 when mismatches are at or below 3 % of the compared bits, and 0 otherwise.

A flag that comes with each bit marks framing bits. Such a bit is never compared. Depending on a mode bit, it is either transparent to the pattern pointer (inserted framing) or still advances it (overwritten framing). Rising and falling edges of each status bit are latched. The latched flags are cleared by writing 1, and they drive an interrupt through a per-detector enable.

Top module: `loop_code_detect`

## Requirements
- R1: After reset, every readable register (addresses 0 to 13) reads 0 and `irq` is 0.
- R2: Register map, all read back on `rd_data`. Address 0 bit 0 holds the framing mode. Addresses 1, 2 and 3 hold the 4-bit length select of detectors 0, 1 and 2. Addresses 4+2i and 5+2i hold the high and low code bytes of detector i. Address 10 holds the status, bit i for detector i. Address 11 holds the rise flags and address 12 the fall flags. Address 13 holds the interrupt enables.
- R3: A length select s from 0 to 7 gives length L = s+1, and the code is the low L bits of the high byte. A select of 8 gives L = 16 and the code {high byte, low byte}. Code bits are expected most significant bit first.
- R4: After a restart, suppose the stream carries the code starting at its first bit, with no errors. The status then rises on the clock edge that takes the WIN_BITS-th strobe, and it is still 0 after WIN_BITS-1 strobes. Status changes only on edges that take a strobe.
- R5: Writing a detector's low code byte or its length select restarts that detector's window, pointer and lock. Its status then holds its value for the next WIN_BITS-1 strobes.
- R6: A window whose mismatches exceed 3 % of its compared bits clears that detector's status at the window's last strobe.
- R7: A code that arrives at an unknown phase, with up to one bit error in 100 bits, is detected within four windows.
- R8: With mode bit 0 = 0 (inserted framing), a flagged bit is not compared and does not advance the pattern pointer.
- R9: With mode bit 0 = 1 (overwritten framing), a flagged bit is not compared but does advance the pattern pointer.
- R10: A status rise sets bit i at address 11, and a status fall sets bit i at address 12. Writing 1 to a bit clears it, and a new event on the same edge wins over the clear.
- R11: `irq` is 1 exactly when some detector has a latched flag set and its enable bit at address 13 is 1.
- R12: Cycles without `bit_en` neither count toward the window nor move the pattern pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe: the serial bit is valid this cycle |
| rx_bit | input | 1 | Serial receive data |
| fbit | input | 1 | Marks the current bit as a framing bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Interrupt, OR of the enabled latched flags |

## Verification
Register writes take effect on the edge that samples them. Read data is combinational, so the bench reads it one time unit after setting `rd_addr`, between clock edges. Status, flags and `irq` follow the edge that takes the WIN_BITS-th strobe of a window. The bench therefore counts strobes from the restart write and samples after the WIN_BITS-1-th and after the WIN_BITS-th strobe. Each of these samples falls on the falling edge after the strobe was taken. The unknown-phase test with errors has no exact edge, so it is checked only after four full windows.

// File: rtl/loop_code_detect.sv
module loop_code_detect #(
  parameter int WIN_BITS = 74112
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_bit,
  input  logic       fbit,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int CW = $clog2(WIN_BITS + 1);
  localparam int ND = 3;

  logic          fmode;
  logic [3:0]    lsel [ND];
  logic [7:0]    chi  [ND];
  logic [7:0]    clo  [ND];
  logic [3:0]    ph   [ND];
  logic [5:0]    run  [ND];
  logic [CW-1:0] wcnt [ND];
  logic [CW-1:0] ecnt [ND];
  logic [CW-1:0] ccnt [ND];
  logic [ND-1:0] lk, lkw, rt, lset, lclr, ien;

  logic [3:0]    phn  [ND];
  logic [CW-1:0] ec   [ND];
  logic [CW-1:0] cc   [ND];
  logic [ND-1:0] rs, mis, pass, wend, lkn, rt_n;

  wire cmp = bit_en && !fbit;
  wire adv = bit_en && (!fbit || fmode);

  always_comb begin
    for (int i = 0; i < ND; i++) begin
      logic [4:0]  len, idx, s, s1, s2;
      logic [15:0] cw;
      logic [CW+7:0] lhs, rhs;
      len = lsel[i][3] ? 5'd16 : {2'b0, lsel[i][2:0]} + 5'd1;
      cw  = lsel[i][3] ? {chi[i], clo[i]} : {8'h00, chi[i]};
      idx = len - 5'd1 - {1'b0, ph[i]};
      mis[i] = cmp && (rx_bit != cw[idx[3:0]]);
      s  = {1'b0, ph[i]} + {4'b0, adv} + {4'b0, mis[i] && !lk[i]};
      s1 = (s >= len) ? s - len : s;
      s2 = (s1 >= len) ? s1 - len : s1;
      phn[i] = s2[3:0];
      ec[i] = ecnt[i] + CW'(mis[i]);
      cc[i] = ccnt[i] + CW'(cmp);
      lhs = {8'd0, ec[i]} * (CW+8)'(100);
      rhs = {8'd0, cc[i]} * (CW+8)'(3);
      pass[i] = (cc[i] != '0) && (lhs <= rhs);
      wend[i] = bit_en && (wcnt[i] == CW'(WIN_BITS - 1));
      lkn[i]  = lk[i] || (cmp && !mis[i] && run[i] == 6'd31);
      rs[i]   = wr_en && (wr_addr == 4'(5 + 2*i) || wr_addr == 4'(1 + i));
      rt_n[i] = (wend[i] && !rs[i]) ? pass[i] : rt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmode <= 1'b0;
      ien   <= '0;
      for (int i = 0; i < ND; i++) begin
        lsel[i] <= '0; chi[i] <= '0; clo[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == 4'd0)  fmode <= wr_data[0];
      if (wr_addr == 4'd13) ien <= wr_data[ND-1:0];
      for (int i = 0; i < ND; i++) begin
        if (wr_addr == 4'(1 + i))   lsel[i] <= wr_data[3:0];
        if (wr_addr == 4'(4 + 2*i)) chi[i]  <= wr_data;
        if (wr_addr == 4'(5 + 2*i)) clo[i]  <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk <= '0; lkw <= '0;
      for (int i = 0; i < ND; i++) begin
        ph[i] <= '0; run[i] <= '0; wcnt[i] <= '0; ecnt[i] <= '0; ccnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ND; i++) begin
        if (rs[i]) begin
          ph[i] <= '0; run[i] <= '0; wcnt[i] <= '0; ecnt[i] <= '0; ccnt[i] <= '0;
          lk[i] <= 1'b0; lkw[i] <= 1'b0;
        end else if (bit_en) begin
          ph[i] <= phn[i];
          if (mis[i]) run[i] <= '0;
          else if (cmp && run[i] != 6'd32) run[i] <= run[i] + 6'd1;
          lk[i] <= lkn[i];
          if (wend[i]) begin
            wcnt[i] <= '0; ecnt[i] <= '0; ccnt[i] <= '0;
            lkw[i]  <= lkn[i];
            if (!pass[i] && lkw[i]) begin
              lk[i] <= 1'b0; lkw[i] <= 1'b0; run[i] <= '0;
            end
          end else begin
            wcnt[i] <= wcnt[i] + CW'(1);
            ecnt[i] <= ec[i];
            ccnt[i] <= cc[i];
          end
        end
      end
    end
  end

  wire [ND-1:0] clr_set = (wr_en && wr_addr == 4'd11) ? wr_data[ND-1:0] : '0;
  wire [ND-1:0] clr_clr = (wr_en && wr_addr == 4'd12) ? wr_data[ND-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt <= '0; lset <= '0; lclr <= '0;
    end else begin
      rt   <= rt_n;
      lset <= (lset & ~clr_set) | (rt_n & ~rt);
      lclr <= (lclr & ~clr_clr) | (~rt_n & rt);
    end
  end

  assign irq = |((lset | lclr) & ien);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      4'd0:  rd_data = {7'd0, fmode};
      4'd10: rd_data = {5'd0, rt};
      4'd11: rd_data = {5'd0, lset};
      4'd12: rd_data = {5'd0, lclr};
      4'd13: rd_data = {5'd0, ien};
      default: begin
        for (int i = 0; i < ND; i++) begin
          if (rd_addr == 4'(1 + i))   rd_data = {4'd0, lsel[i]};
          if (rd_addr == 4'(4 + 2*i)) rd_data = chi[i];
          if (rd_addr == 4'(5 + 2*i)) rd_data = clo[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/loop_code_detect_chk.sv
module lcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic       irq,
  input logic [2:0] rt,
  input logic [2:0] lset,
  input logic [2:0] lclr
);
  for (genvar i = 0; i < 3; i++) begin : g_det
    p_rt_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(rt[i]));
    p_restart_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == 4'(5 + 2*i) || wr_addr == 4'(1 + i))) |=> $stable(rt[i]));
    p_rise_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rt[i]) |-> lset[i]);
    p_fall_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rt[i]) |-> lclr[i]);
  end

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(lset | lclr));
endmodule

bind loop_code_detect lcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .irq(irq), .rt(rt), .lset(lset), .lclr(lclr)
);

// File: tb/tb_loop_code_detect.sv
module tb_loop_code_detect;
  localparam int CLK = 10;
  localparam int WIN = 256;

  logic       clk = 0, rst_n = 0, bit_en = 0, rx_bit = 0, fbit = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0, errs = 0;
  bit gaps_on = 0, done = 0;

  loop_code_detect #(.WIN_BITS(WIN)) dut (.*);

  always #(CLK/2) clk = ~clk;

  function automatic logic patbit(input logic [15:0] cw, input int len, input int k);
    return cw[len - 1 - (k % len)];
  endfunction

  function automatic logic [15:0] codeword(input logic [3:0] sel, input logic [7:0] hi, input logic [7:0] lo);
    return (sel == 4'd8) ? {hi, lo} : {8'h00, hi};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic strobe(input logic b, input logic f);
    if (gaps_on) repeat ($urandom_range(0, 2)) @(negedge clk);
    @(negedge clk); bit_en = 1; rx_bit = b; fbit = f;
    @(negedge clk); bit_en = 0;
  endtask

  task automatic garbage(input int n);
    for (int j = 0; j < n; j++) strobe(1'($urandom), 1'b0);
  endtask

  task automatic aligned(input logic [15:0] cw, input int len, input int n);
    for (int j = 0; j < n; j++) strobe(patbit(cw, len, j), 1'b0);
  endtask

  task automatic rt_bit(input int i, input string tag, input int exp);
    logic [7:0] v;
    rd(4'd10, v);
    chk(tag, v[i], exp);
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] rv [10];
    logic [15:0] cw;
    int k;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 14; a++) begin
      rd(4'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", irq, 0);

    // R2 register readback
    for (int a = 1; a < 10; a++) begin
      rv[a] = 8'($urandom);
      wr(4'(a), rv[a]);
    end
    for (int a = 1; a < 10; a++) begin
      rd(4'(a), v);
      chk("R2 readback", v, (a < 4) ? {4'd0, rv[a][3:0]} : rv[a]);
    end
    wr(4'd0, 8'h01); rd(4'd0, v); chk("R2 mode bit", v, 1);
    wr(4'd0, 8'h00);

    wr(4'd2, 8'd0); wr(4'd6, 8'h00); wr(4'd7, 8'h00);
    wr(4'd3, 8'd8); wr(4'd8, 8'hFF); wr(4'd9, 8'hFF);

    // R3 R4 R12 exact integration, 5-bit code 10110, strobe gaps
    gaps_on = 1;
    wr(4'd1, 8'd4); wr(4'd4, 8'h16); wr(4'd5, 8'h00);
    cw = codeword(4'd4, 8'h16, 8'h00);
    aligned(cw, 5, WIN - 1);
    rd(4'd10, v); chk("R4 status before window end", v, 0);
    strobe(patbit(cw, 5, WIN - 1), 1'b0);
    rd(4'd10, v); chk("R4 R3 status at window end", v, 1);
    rd(4'd11, v); chk("R10 rise flag", v, 1);
    rd(4'd12, v); chk("R10 no fall flag", v, 0);
    repeat (5) @(negedge clk);
    rt_bit(0, "R12 idle cycles hold status", 1);

    // R11 interrupt gating, R10 clear by writing 1
    chk("R11 irq disabled", irq, 0);
    wr(4'd13, 8'h01); #1; chk("R11 irq enabled", irq, 1);
    wr(4'd13, 8'h06); #1; chk("R11 irq other enables", irq, 0);
    wr(4'd13, 8'h01);
    wr(4'd11, 8'h01);
    rd(4'd11, v); chk("R10 rise flag cleared", v, 0);
    #1; chk("R11 irq after clear", irq, 0);

    // R5 restart holds status, R6 failing window clears it
    garbage(40);
    wr(4'd5, 8'h3C);
    garbage(WIN - 1);
    rt_bit(0, "R5 status held after restart", 1);
    garbage(1);
    rt_bit(0, "R6 status cleared on failing window", 0);
    rd(4'd12, v); chk("R10 fall flag", v, 1);
    #1; chk("R11 irq on fall flag", irq, 1);
    wr(4'd12, 8'h01);
    rd(4'd12, v); chk("R10 fall flag cleared", v, 0);

    // R3 every short length
    for (int s = 0; s < 8; s++) begin
      logic [7:0] c;
      c = 8'($urandom);
      wr(4'd1, 8'(s)); wr(4'd4, c); wr(4'd5, 8'h00);
      garbage(WIN);
      rt_bit(0, "R6 short length garbage", 0);
      wr(4'd5, 8'h00);
      cw = codeword(4'(s), c, 8'h00);
      aligned(cw, s + 1, WIN - 1);
      rt_bit(0, "R3 short length before end", 0);
      strobe(patbit(cw, s + 1, WIN - 1), 1'b0);
      rt_bit(0, "R3 short length detected", 1);
    end

    // R7 16-bit code, unknown phase, 1 % errors
    do cw = 16'($urandom); while ($countones(cw) < 5 || $countones(cw) > 11);
    wr(4'd8, cw[15:8]); wr(4'd9, cw[7:0]);
    k = $urandom_range(0, 15);
    for (int n = 0; n < 4 * WIN; n++) begin
      logic b;
      b = patbit(cw, 16, k + n);
      strobe((n % 100 == 37) ? ~b : b, 1'b0);
    end
    rt_bit(2, "R7 R3 16-bit code with errors", 1);

    // R8 inserted framing bits
    gaps_on = 0;
    wr(4'd0, 8'h00); wr(4'd2, 8'd2); wr(4'd6, 8'h06); wr(4'd7, 8'h00);
    cw = 16'h0006;
    k = 0;
    for (int n = 0; n < WIN; n++) begin
      if (n == WIN - 1) rt_bit(1, "R8 insert before end", 0);
      if (n % 24 == 23) strobe(1'($urandom), 1'b1);
      else begin strobe(patbit(cw, 3, k), 1'b0); k++; end
    end
    rt_bit(1, "R8 insert detected", 1);

    // R6 loss, then R9 overwritten framing bits
    garbage(2 * WIN);
    rt_bit(1, "R6 down detector cleared", 0);
    wr(4'd0, 8'h01); wr(4'd7, 8'h00);
    for (int n = 0; n < WIN; n++) begin
      if (n == WIN - 1) rt_bit(1, "R9 overwrite before end", 0);
      if (n % 24 == 23) strobe(~patbit(cw, 3, n), 1'b1);
      else strobe(patbit(cw, 3, n), 1'b0);
    end
    rt_bit(1, "R9 overwrite detected", 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule